// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the transfer core of a full-duplex SPI master. Software-style control pins select the clock idle level and the sampling phase, the bit order and a frame length between 4 and 16 bits. A single handshake then launches one frame. The engine pulls slave select low and produces exactly as many SCK pulses as the frame has bits. It shifts the transmit word out on MOSI while it collects MISO into a right-aligned receive word. After the last sampling edge it releases slave select half an SCK period later.

SCK is derived from the system clock: every SCK half period lasts `HALF_DIV` system clocks (at least 1). The configuration fields are captured only while the engine is disabled, so a running or armed engine cannot be reconfigured by mistake. A frame is started with a valid/ready handshake on the transmit side. The receive side is a one-cycle valid pulse with no back-pressure: the received word stays on `rx_data` until the next frame completes, and a consumer that is not ready simply reads it later. A start request is only taken when `tx_valid` and `tx_ready` are both high in the same cycle. `tx_ready` is low while disabled or busy, and `tx_valid` is not required to stay high until accepted.

Top module: `spi_master_engine`

## Requirements
- R1: All four combinations of `cfg_cpol`/`cfg_cpha` give full-duplex frames. Counting SCK edges from 1 after slave select falls: with phase 0, odd edges sample and even edges change data, and the first MOSI bit is valid from the cycle slave select falls. With phase 1, odd edges change data and even edges sample.
- R2: While no frame is in progress, `sck` rests at the stored polarity: 0 for polarity 0 and 1 for polarity 1.
- R3: The stored configuration (polarity, phase, bit order, length) is written from the `cfg_*` inputs on a clock where `cfg_wr` is 1 and `cfg_en` is 0. When `cfg_en` is 1, `cfg_wr` has no effect.
- R4: With `cfg_lsb_first` = 1, bit 0 of the word is the first on the wire; with 0, bit N-1 is first. The same order is used for received bits.
- R5: `cfg_len` holds the frame length N in bits directly. Codes below 4 are stored as 4 and codes above 16 as 16.
- R6: A frame of N bits produces exactly N SCK pulses (2N edges) and leaves `sck` at the idle level.
- R7: Data is right-aligned: `tx_data` bits at N and above are never sent, and `rx_data` bits at N and above read 0.
- R8: `ss_n` stays low for 2N half periods with phase 0 and 2N+1 half periods with phase 1, each half period being `HALF_DIV` clocks. This releases it one half period after the last sampling edge.
- R9: `busy` is high exactly while `ss_n` is low. `rx_valid` is a single-cycle pulse in the cycle `ss_n` rises, and `rx_data` then holds until the next frame ends.
- R10: `tx_ready` equals `cfg_en` and not `busy`. A `tx_valid` while disabled or while busy starts nothing and does not disturb the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Engine enable; locks the configuration while high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cpol | input | 1 | SCK idle level to store |
| cfg_cpha | input | 1 | Sampling phase to store |
| cfg_lsb_first | input | 1 | Bit order to store (1 = LSB first) |
| cfg_len | input | 5 | Frame length in bits to store |
| tx_valid | input | 1 | Start request carrying `tx_data` |
| tx_ready | output | 1 | Engine can accept a start request |
| tx_data | input | 16 | Right-aligned transmit word |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` updated |
| rx_data | output | 16 | Right-aligned received word |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A bench-side slave model follows SCK and slave select. It drives MISO on the change edges and captures MOSI on the sampling edges for every polarity, phase, bit order and frame length from 4 to 16. The transmit and slave words carry ones above the frame, so a wrong mask, reversed order or an off-by-one length shows up as a corrupted word. The pulse count, slave-select width and final SCK level separate the two phases and catch a missing or extra edge. Further runs try start requests while disabled or busy, configuration writes while enabled, and out-of-range length codes, each observed through the pins.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int CFG_LEN_W = 5;

  typedef struct packed {
    logic                 cpol;
    logic                 cpha;
    logic                 lsb_first;
    logic [CFG_LEN_W-1:0] len;
  } spi_cfg_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } eng_state_e;

  // Word bit index of the k-th bit on the wire for a frame of len bits.
  function automatic logic [CFG_LEN_W-1:0] wire_pos(
    input logic                 lsb_first,
    input logic [CFG_LEN_W-1:0] len,
    input logic [CFG_LEN_W-1:0] k
  );
    wire_pos = lsb_first ? k : (len - CFG_LEN_W'(1) - k);
  endfunction

endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_eng_pkg::*;
#(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eng_en,
  input  logic                 wr,
  input  logic                 cpol_in,
  input  logic                 cpha_in,
  input  logic                 lsb_in,
  input  logic [CFG_LEN_W-1:0] len_in,
  output spi_cfg_t             cfg
);

  localparam logic [CFG_LEN_W-1:0] LEN_LO = CFG_LEN_W'(MIN_LEN);
  localparam logic [CFG_LEN_W-1:0] LEN_HI = CFG_LEN_W'(MAX_LEN);

  logic [CFG_LEN_W-1:0] len_clamped;

  always_comb begin
    if (len_in < LEN_LO)      len_clamped = LEN_LO;
    else if (len_in > LEN_HI) len_clamped = LEN_HI;
    else                      len_clamped = len_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{cpol: 1'b0, cpha: 1'b0, lsb_first: 1'b0, len: LEN_HI};
    end else if (wr && !eng_en) begin
      cfg <= '{cpol: cpol_in, cpha: cpha_in, lsb_first: lsb_in, len: len_clamped};
    end
  end

endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= RELOAD;
    end else if (run) begin
      cnt <= (cnt == '0) ? RELOAD : cnt - CNT_W'(1);
    end
  end

  assign tick = run && (cnt == '0);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 first_now,
  input  logic                 shift_out,
  input  logic                 sample_in,
  input  logic                 park,
  input  logic                 lsb_first,
  input  logic [CFG_LEN_W-1:0] len,
  input  logic [DATA_W-1:0]    tx_word,
  input  logic                 miso,
  output logic                 mosi,
  output logic [DATA_W-1:0]    rx_word
);

  logic [DATA_W-1:0]    tx_hold;
  logic [CFG_LEN_W-1:0] tx_k, rx_k;
  logic [CFG_LEN_W-1:0] tx_pos, rx_pos, pos0;
  logic [DATA_W-1:0]    tx_sel, rx_sel, first_sel;
  logic [DATA_W-1:0]    rx_next;
  logic                 next_bit, first_bit;

  always_comb begin
    tx_pos = wire_pos(lsb_first, len, tx_k);
    rx_pos = wire_pos(lsb_first, len, rx_k);
    pos0   = wire_pos(lsb_first, len, '0);
  end

  // One-hot position decoders: bit i of the word is on the wire now.
  for (genvar i = 0; i < DATA_W; i++) begin : g_sel
    assign tx_sel[i]    = (tx_pos == CFG_LEN_W'(i));
    assign rx_sel[i]    = (rx_pos == CFG_LEN_W'(i));
    assign first_sel[i] = (pos0 == CFG_LEN_W'(i));
  end

  assign next_bit  = |(tx_hold & tx_sel);
  assign first_bit = |(tx_word & first_sel);

  always_comb begin
    rx_next = rx_word;
    for (int i = 0; i < DATA_W; i++) begin
      if (rx_sel[i]) rx_next[i] = miso;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold <= '0;
      tx_k    <= '0;
      rx_k    <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
    end else if (load) begin
      tx_hold <= tx_word;
      rx_word <= '0;
      rx_k    <= '0;
      if (first_now) begin
        mosi <= first_bit;
        tx_k <= CFG_LEN_W'(1);
      end else begin
        mosi <= 1'b0;
        tx_k <= '0;
      end
    end else begin
      if (shift_out) begin
        mosi <= next_bit;
        tx_k <= tx_k + CFG_LEN_W'(1);
      end else if (park) begin
        mosi <= 1'b0;
      end
      if (sample_in) begin
        rx_word <= rx_next;
        rx_k    <= rx_k + CFG_LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MIN_LEN  = 4,
  parameter int MAX_LEN  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_wr,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  input  logic                 cfg_lsb_first,
  input  logic [CFG_LEN_W-1:0] cfg_len,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [MAX_LEN-1:0]   tx_data,
  output logic                 rx_valid,
  output logic [MAX_LEN-1:0]   rx_data,
  output logic                 busy,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 ss_n
);

  localparam int DATA_W = MAX_LEN;
  localparam int EDGE_W = CFG_LEN_W + 1;

  spi_cfg_t          cfg;
  eng_state_e        state;
  logic [EDGE_W-1:0] edge_cnt, edge_num, two_n, last_tick;
  logic              tick, accept;
  logic              do_toggle, do_sample, do_drive, do_finish;
  logic [DATA_W-1:0] rx_word;

  spi_cfg_regs #(
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .eng_en  (cfg_en),
    .wr      (cfg_wr),
    .cpol_in (cfg_cpol),
    .cpha_in (cfg_cpha),
    .lsb_in  (cfg_lsb_first),
    .len_in  (cfg_len),
    .cfg     (cfg)
  );

  assign tx_ready = cfg_en && (state == ST_IDLE);
  assign accept   = tx_valid && tx_ready;
  assign busy     = (state == ST_SHIFT);

  spi_clk_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .tick    (tick)
  );

  // Edge bookkeeping: ticks are numbered 1.. from the fall of slave select.
  always_comb begin
    edge_num  = edge_cnt + EDGE_W'(1);
    two_n     = {cfg.len, 1'b0};
    last_tick = two_n + EDGE_W'(cfg.cpha);
    do_toggle = tick && (edge_num <= two_n);
    do_sample = do_toggle && (edge_num[0] ^ cfg.cpha);
    do_drive  = tick && (edge_num < two_n) && (edge_num[0] == cfg.cpha);
    do_finish = tick && (edge_num == last_tick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      ss_n     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SHIFT;
            edge_cnt <= '0;
            ss_n     <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) edge_cnt <= edge_num;
          if (do_finish) begin
            state <= ST_IDLE;
            ss_n  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck <= 1'b0;
    end else if (state == ST_IDLE) begin
      sck <= cfg.cpol;
    end else if (do_toggle) begin
      sck <= ~sck;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= do_finish;
      if (do_finish) rx_data <= rx_word;
    end
  end

  spi_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .first_now (!cfg.cpha),
    .shift_out (do_drive),
    .sample_in (do_sample),
    .park      (do_finish),
    .lsb_first (cfg.lsb_first),
    .len       (cfg.len),
    .tx_word   (tx_data),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk
  import spi_eng_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     cfg_en,
  input logic     tx_valid,
  input logic     busy,
  input logic     ss_n,
  input logic     sck,
  input logic     rx_valid,
  input spi_cfg_t cfg_q
);

  // R2: idle clock level follows the stored polarity
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cfg_q.cpol)) |-> (sck == cfg_q.cpol));

  // R3: stored configuration frozen while enabled
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(cfg_q));

  // R6: a frame ends with the clock back at its idle level
  p_end_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (sck == cfg_q.cpol));

  // R8: completion coincides with slave-select release
  p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(ss_n));

  // R9: busy mirrors slave select
  p_busy_ss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy != ss_n);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: a frame only starts from an accepted request
  p_start_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(tx_valid && cfg_en && !busy));

endmodule

bind spi_master_engine spi_master_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .tx_valid (tx_valid),
  .busy     (busy),
  .ss_n     (ss_n),
  .sck      (sck),
  .rx_valid (rx_valid),
  .cfg_q    (cfg)
);

// File: tb/spi_master_engine_bench.sv
module spi_master_engine_bench;
  import spi_eng_pkg::*;

  localparam int DIV = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n, cfg_en, cfg_wr, cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [CFG_LEN_W-1:0] cfg_len;
  logic                 tx_valid, tx_ready, rx_valid, busy, sck, mosi, miso, ss_n;
  logic [15:0]          tx_data, rx_data;

  spi_master_engine #(.HALF_DIV(DIV), .MIN_LEN(4), .MAX_LEN(16)) u_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Slave model and frame monitor
  logic [15:0] s_word = '0;
  logic [15:0] cap = '0;
  bit          s_cpha = 1'b0, s_lsb = 1'b0;
  int          s_len = 8;
  int          edges = 0, kin = 0, kout = 0, ss_low = 0, rxv = 0;
  logic        sck_prev = 1'b0, ss_prev = 1'b1;

  function automatic int pos(input int k);
    return s_lsb ? k : (s_len - 1 - k);
  endfunction

  always @(negedge clk) begin
    if (ss_n === 1'b0) ss_low++;
    if (rx_valid === 1'b1) rxv++;
    if (ss_prev === 1'b1 && ss_n === 1'b0) begin
      kin  = 0;
      kout = 0;
      if (!s_cpha) begin
        miso = s_word[pos(0)];
        kout = 1;
      end
    end
    if (sck !== sck_prev) begin
      edges++;
      if (((edges % 2) == 1) != s_cpha) begin
        if (kin < s_len) cap[pos(kin)] = mosi;
        kin++;
      end else if (edges < 2 * s_len && kout < s_len) begin
        miso = s_word[pos(kout)];
        kout++;
      end
    end
    sck_prev = sck;
    ss_prev  = ss_n;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic configure(input bit pol, input bit pha, input bit lsb, input int code);
    step();
    cfg_en = 1'b0; cfg_wr = 1'b1;
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_len = CFG_LEN_W'(code);
    step();
    cfg_wr = 1'b0; cfg_en = 1'b1;
    repeat (3) step();
  endtask

  task automatic launch(input logic [15:0] tx, input logic [15:0] sw, input bit pha,
                        input bit lsb, input int n);
    s_word = sw; s_cpha = pha; s_lsb = lsb; s_len = n;
    cap = '0; edges = 0; ss_low = 0; rxv = 0;
    tx_data = tx; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (rxv == 0 && guard < 1000) begin
      step();
      guard++;
    end
    step();
  endtask

  task automatic check_frame(input string tag, input bit pol, input bit pha, input int n,
                             input logic [15:0] tx, input logic [15:0] sw);
    int mask = (1 << n) - 1;
    chk("R1/R4/R7", {tag, " rx word"}, int'(rx_data), int'(sw) & mask);
    chk("R1/R4/R7", {tag, " mosi word"}, int'(cap), int'(tx) & mask);
    chk("R6", {tag, " sck edges"}, edges, 2 * n);
    chk("R8", {tag, " ss low cycles"}, ss_low, (2 * n + int'(pha)) * DIV);
    chk("R2", {tag, " idle sck"}, int'(sck), int'(pol));
    chk("R9", {tag, " done pulses"}, rxv, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual no completion expected run to finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_wr = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_lsb_first = 1'b0; cfg_len = '0; tx_valid = 1'b0; tx_data = '0; miso = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // Reset state
    chk("R9", "reset ss_n", int'(ss_n), 1);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R2", "reset sck", int'(sck), 0);
    chk("R9", "reset rx_valid", int'(rx_valid), 0);
    chk("R9", "reset rx_data", int'(rx_data), 0);
    chk("R10", "reset tx_ready", int'(tx_ready), 0);

    // Full sweep: every mode, order and length
    begin
      int it = 0;
      for (int m = 0; m < 4; m++) begin
        for (int lsb = 0; lsb < 2; lsb++) begin
          for (int n = 4; n <= 16; n++) begin
            logic [15:0] tx, sw;
            bit pol, pha;
            pol = bit'(m / 2);
            pha = bit'(m % 2);
            tx = 16'((it * 40503 + 12345) | 32'hC000);
            sw = 16'((it * 9973 + 777) | 32'h8000);
            configure(pol, pha, bit'(lsb), n);
            chk("R2", "idle sck before frame", int'(sck), int'(pol));
            chk("R10", "ready when enabled", int'(tx_ready), 1);
            launch(tx, sw, pha, bit'(lsb), n);
            wait_done();
            check_frame("sweep", pol, pha, n, tx, sw);
            it++;
          end
        end
      end
    end

    // R9: received word holds after completion
    begin
      logic [15:0] held;
      held = rx_data;
      repeat (6) step();
      chk("R9", "rx_data hold", int'(rx_data), int'(held));
      chk("R9", "busy low after frame", int'(busy), 0);
    end

    // R10: start while disabled is ignored
    configure(1'b0, 1'b1, 1'b0, 8);
    cfg_en = 1'b0;
    rxv = 0; ss_low = 0;
    tx_data = 16'hA5A5; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
    repeat (10) step();
    chk("R10", "disabled start ss_n", int'(ss_n), 1);
    chk("R10", "disabled start ss_low", ss_low, 0);
    chk("R10", "disabled start done", rxv, 0);
    chk("R10", "disabled tx_ready", int'(tx_ready), 0);

    // R10: start while busy is ignored
    configure(1'b1, 1'b0, 1'b1, 12);
    launch(16'h3C96, 16'h0F5A, 1'b0, 1'b1, 12);
    repeat (8) step();
    chk("R10", "tx_ready while busy", int'(tx_ready), 0);
    tx_data = 16'hFFFF; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
    wait_done();
    check_frame("busy-start", 1'b1, 1'b0, 12, 16'h3C96, 16'h0F5A);
    repeat (20) step();
    chk("R10", "no second frame ss_n", int'(ss_n), 1);
    chk("R10", "no second frame done", rxv, 1);

    // R3: configuration writes while enabled are ignored
    configure(1'b0, 1'b0, 1'b0, 8);
    cfg_wr = 1'b1; cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb_first = 1'b1; cfg_len = 5'd5;
    step();
    cfg_wr = 1'b0;
    repeat (3) step();
    chk("R3", "locked polarity sck", int'(sck), 0);
    launch(16'h12C3, 16'h00B4, 1'b0, 1'b0, 8);
    wait_done();
    check_frame("R3 locked", 1'b0, 1'b0, 8, 16'h12C3, 16'h00B4);

    // R5: out-of-range length codes clamp
    configure(1'b0, 1'b1, 1'b0, 2);
    launch(16'hFFF6, 16'hFFF9, 1'b1, 1'b0, 4);
    wait_done();
    check_frame("R5 short clamp", 1'b0, 1'b1, 4, 16'hFFF6, 16'hFFF9);
    configure(1'b1, 1'b1, 1'b1, 31);
    launch(16'hBEEF, 16'h6D2B, 1'b1, 1'b1, 16);
    wait_done();
    check_frame("R5 long clamp", 1'b1, 1'b1, 16, 16'hBEEF, 16'h6D2B);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule